// File: doc/BRIEF.md
# Command Bus Window Slot Scheduler

This block decides when a command may go out on a command bus that is shared by many requesters. Time runs as a cycle count kept inside the block. The count is cut into aligned windows of a fixed length, and each window may carry only a limited number of commands. A caller presents a requested issue time. For a one-slot command, the block finds the first window at or after that time that still has a free slot. It reserves the slot and returns the issue time. For a two-part command, it places the first part in an earlier window and the second part at the requested time. It makes sure that both parts get slots and that the distance between their windows stays within a set limit.

Occupancy lives in a small circular table of per-window counters. The table covers the current window and the windows that follow it. When time moves past a window, that window's counter is cleared and the entry is reused for the window that has just entered the far end of the table. The grant comes back one cycle after the request, together with a one-cycle done strobe. Its reservation is visible to the request that follows it.

Top module: `cbw_window_sched`

## Requirements
- R1: After reset, `now_time` is 0, `grant_done` is low and every window counter is empty, so a first request is granted at its requested time.
- R2: `now_time` rises by exactly one on every clock edge after reset.
- R3: A one-slot request whose window holds fewer than `MAX_CMDS` commands is granted at its requested time, and `grant_first` equals `grant_time`.
- R4: A requested time earlier than `now_time` is treated as `now_time`, so no grant is ever earlier than the time at which the request was taken.
- R5: When the window of a one-slot request is full, the command moves to the start (time a multiple of 2^`WIN_LOG2`) of the next window, and this repeats until a window with room is found.
- R6: No window counter ever holds more than `MAX_CMDS` commands.
- R7: For a two-part request, the first part's window begins `SPLIT_WIN` windows before the second part's window, but never before the current window. `grant_first` is the later of that window's start and `now_time`. The granted windows are never more than `SPLIT_WIN` apart.
- R8: When both parts of a two-part request fall in the same window, they count as two commands in that window.
- R9: For a two-part request where a part does not fit, the steps are as follows. If the second part lacks a slot, its window advances by one. Then, if the first part lacked a slot, or the second lacked one and the windows are now more than `SPLIT_WIN` apart, the first window advances by one. The check then repeats.
- R10: A window that time has left is cleared, and its table entry serves the window `2^NWIN_LOG2` windows later as an empty window.
- R11: A request whose search would reach or pass the window `2^NWIN_LOG2` windows after the current one is refused. It returns `grant_ok` low with both times 0 and reserves nothing.
- R12: `grant_done` is high for exactly the one cycle after each cycle in which `req_valid` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_pair | input | 1 | 1: two-part command, 0: one-slot command |
| req_time | input | TW | Requested issue time (of the second part for a pair) |
| now_time | output | TW | Current time, in cycles since reset |
| grant_done | output | 1 | Result strobe, one cycle after the request |
| grant_ok | output | 1 | Slots were found and reserved |
| grant_first | output | TW | Issue time of the first part (equals grant_time for one-slot) |
| grant_time | output | TW | Issue time of the command or of its second part |

## Verification
Every result is registered. The done strobe, the ok flag and both issue times are due on the clock edge that takes the request, and the reservation counts for a request presented on the very next edge. The bench drives each request on a falling edge and reads all outputs on the following falling edge, half a cycle after that rising edge, so exactly one register stage separates stimulus from result. Its model predicts the grant from the time at the moment the request was presented, and it advances its own time count and occupancy record on the same edge as the design.

// File: rtl/cbw_pkg.sv
package cbw_pkg;

    // Kind of command presented on a request
    typedef enum logic {
        CMD_SINGLE = 1'b0,
        CMD_PAIR   = 1'b1
    } cmd_kind_e;

endpackage

// File: rtl/cbw_occupancy.sv
// Circular table of per-window command counters. Entry k holds the
// count of the window whose number has k as its low bits.
module cbw_occupancy #(
    parameter int unsigned NWIN_LOG2 = 3,
    parameter int unsigned CNT_W     = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  clr_en,
    input  logic [NWIN_LOG2-1:0]                  clr_idx,
    input  logic                                  inc_a_en,
    input  logic [NWIN_LOG2-1:0]                  inc_a_idx,
    input  logic                                  inc_b_en,
    input  logic [NWIN_LOG2-1:0]                  inc_b_idx,
    output logic [(1<<NWIN_LOG2)-1:0][CNT_W-1:0]  occ
);
    localparam int unsigned NW = 1 << NWIN_LOG2;

    typedef struct packed {
        logic [NW-1:0][CNT_W-1:0] cnt;
    } occ_state_t;

    occ_state_t st_d, st_q;
    logic [CNT_W-1:0] add_a, add_b;

    always_comb begin
        st_d  = st_q;
        add_a = '0;
        add_b = '0;
        for (int i = 0; i < NW; i++) begin
            add_a = CNT_W'(inc_a_en && (inc_a_idx == NWIN_LOG2'(i)));
            add_b = CNT_W'(inc_b_en && (inc_b_idx == NWIN_LOG2'(i)));
            st_d.cnt[i] = st_q.cnt[i] + add_a + add_b;
            // a window leaving the past side is cleared; this wins over a
            // reservation into it made on the same edge
            if (clr_en && (clr_idx == NWIN_LOG2'(i))) begin
                st_d.cnt[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ = st_q.cnt;

endmodule

// File: rtl/cbw_search.sv
// Combinational slot search over window offsets relative to the current
// window. Offsets at or past the table depth mean no room.
module cbw_search #(
    parameter int unsigned NWIN_LOG2 = 3,
    parameter int unsigned CNT_W     = 2,
    parameter int unsigned MAX_CMDS  = 2,
    parameter int unsigned SPLIT_WIN = 1
) (
    input  logic [(1<<NWIN_LOG2)-1:0][CNT_W-1:0] occ,
    input  logic [NWIN_LOG2-1:0]                 base_idx,
    input  logic [NWIN_LOG2-1:0]                 start_off,
    input  logic                                 pair,
    output logic                                 found,
    output logic [NWIN_LOG2-1:0]                 first_off,
    output logic [NWIN_LOG2-1:0]                 second_off
);
    localparam int unsigned NW    = 1 << NWIN_LOG2;
    localparam int unsigned OW    = NWIN_LOG2 + 1;
    localparam int unsigned STEPS = 2 * NW + 2;
    localparam logic [CNT_W-1:0] LIM_C  = CNT_W'(MAX_CMDS);
    localparam logic [CNT_W:0]   LIM_S  = (CNT_W + 1)'(MAX_CMDS);
    localparam logic [OW-1:0]    SPLIT  = OW'(SPLIT_WIN);

    logic [OW-1:0]        s, f;
    logic [NWIN_LOG2-1:0] fi, si;
    logic [CNT_W-1:0]     fc, s_cnt;
    logic [CNT_W:0]       sc;
    logic                 hit, dead, same, fok, sok, gap;

    always_comb begin
        s = {1'b0, start_off};
        f = s;
        if (pair) begin
            f = (s >= SPLIT) ? (s - SPLIT) : '0;
        end
        hit = 1'b0; dead = 1'b0;
        fi = '0; si = '0; fc = '0; s_cnt = '0; sc = '0;
        same = 1'b0; fok = 1'b0; sok = 1'b0; gap = 1'b0;
        for (int it = 0; it < STEPS; it++) begin
            if (!hit && !dead) begin
                if (s[OW-1]) begin
                    dead = 1'b1;
                end else begin
                    fi    = base_idx + f[NWIN_LOG2-1:0];
                    si    = base_idx + s[NWIN_LOG2-1:0];
                    fc    = occ[fi];
                    s_cnt = occ[si];
                    same  = (f == s);
                    sc    = same ? ({1'b0, fc} + 1'b1) : {1'b0, s_cnt};
                    if (!pair) begin
                        if (s_cnt < LIM_C) hit = 1'b1;
                        else               s = s + 1'b1;
                    end else begin
                        fok = (fc < LIM_C);
                        sok = (sc < LIM_S);
                        if (fok && sok) begin
                            hit = 1'b1;
                        end else begin
                            if (!sok) s = s + 1'b1;
                            gap = !same && ((s - f) > SPLIT);
                            if (!fok || (!sok && gap)) f = f + 1'b1;
                        end
                    end
                end
            end
        end
        found      = hit;
        second_off = s[NWIN_LOG2-1:0];
        first_off  = pair ? f[NWIN_LOG2-1:0] : s[NWIN_LOG2-1:0];
    end

endmodule

// File: rtl/cbw_window_sched.sv
module cbw_window_sched #(
    parameter int unsigned TW        = 32,
    parameter int unsigned WIN_LOG2  = 2,
    parameter int unsigned NWIN_LOG2 = 3,
    parameter int unsigned MAX_CMDS  = 2,
    parameter int unsigned SPLIT_WIN = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_pair,
    input  logic [TW-1:0] req_time,
    output logic [TW-1:0] now_time,
    output logic          grant_done,
    output logic          grant_ok,
    output logic [TW-1:0] grant_first,
    output logic [TW-1:0] grant_time
);
    import cbw_pkg::*;

    localparam int unsigned NW    = 1 << NWIN_LOG2;
    localparam int unsigned WW    = TW - WIN_LOG2;
    localparam int unsigned CNT_W = $clog2(MAX_CMDS + 1);

    typedef struct packed {
        logic [TW-1:0] now;
        logic          done;
        logic          ok;
        logic [TW-1:0] t1;
        logic [TW-1:0] t2;
    } sched_state_t;

    sched_state_t st_d, st_q;

    cmd_kind_e                    kind;
    logic                         pair;
    logic [TW-1:0]                tc;
    logic [WW-1:0]                cur_win, req_win, delta;
    logic                         in_range, found, take;
    logic [NWIN_LOG2-1:0]         base_idx, start_off, f_off, s_off;
    logic [TW-1:0]                f_start, s_start, t1_c, t2_c;
    logic [NW-1:0][CNT_W-1:0]     occ;

    assign kind      = cmd_kind_e'(req_pair);
    assign pair      = (kind == CMD_PAIR);
    assign cur_win   = st_q.now[TW-1:WIN_LOG2];
    assign base_idx  = cur_win[NWIN_LOG2-1:0];
    assign tc        = (req_time < st_q.now) ? st_q.now : req_time;
    assign req_win   = tc[TW-1:WIN_LOG2];
    assign delta     = req_win - cur_win;
    assign in_range  = (delta < WW'(NW));
    assign start_off = delta[NWIN_LOG2-1:0];

    cbw_search #(
        .NWIN_LOG2 (NWIN_LOG2),
        .CNT_W     (CNT_W),
        .MAX_CMDS  (MAX_CMDS),
        .SPLIT_WIN (SPLIT_WIN)
    ) u_search (
        .occ        (occ),
        .base_idx   (base_idx),
        .start_off  (start_off),
        .pair       (pair),
        .found      (found),
        .first_off  (f_off),
        .second_off (s_off)
    );

    assign take = req_valid && in_range && found;

    cbw_occupancy #(
        .NWIN_LOG2 (NWIN_LOG2),
        .CNT_W     (CNT_W)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (&st_q.now[WIN_LOG2-1:0]),
        .clr_idx   (base_idx),
        .inc_a_en  (take),
        .inc_a_idx (base_idx + s_off),
        .inc_b_en  (take && pair),
        .inc_b_idx (base_idx + f_off),
        .occ       (occ)
    );

    always_comb begin
        s_start = {cur_win + WW'(s_off), {WIN_LOG2{1'b0}}};
        f_start = {cur_win + WW'(f_off), {WIN_LOG2{1'b0}}};
        t2_c    = (s_off == start_off) ? tc : s_start;
        t1_c    = t2_c;
        if (pair) begin
            t1_c = (f_start < st_q.now) ? st_q.now : f_start;
        end

        st_d      = st_q;
        st_d.now  = st_q.now + 1'b1;
        st_d.done = req_valid;
        st_d.ok   = take;
        st_d.t1   = take ? t1_c : '0;
        st_d.t2   = take ? t2_c : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now_time    = st_q.now;
    assign grant_done  = st_q.done;
    assign grant_ok    = st_q.ok;
    assign grant_first = st_q.t1;
    assign grant_time  = st_q.t2;

endmodule

// File: rtl/cbw_window_sched_chk.sv
module cbw_window_sched_chk #(
    parameter int unsigned TW        = 32,
    parameter int unsigned WIN_LOG2  = 2,
    parameter int unsigned NWIN_LOG2 = 3,
    parameter int unsigned MAX_CMDS  = 2,
    parameter int unsigned SPLIT_WIN = 1,
    parameter int unsigned CNT_W     = 2
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 req_valid,
    input logic [TW-1:0]                        now_time,
    input logic                                 grant_done,
    input logic                                 grant_ok,
    input logic [TW-1:0]                        grant_first,
    input logic [TW-1:0]                        grant_time,
    input logic [(1<<NWIN_LOG2)-1:0][CNT_W-1:0] occ
);
    localparam int unsigned NW = 1 << NWIN_LOG2;

    p_now_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (now_time == $past(now_time) + 1'b1));

    p_done_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> grant_done);

    p_no_stray_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !grant_done);

    p_not_in_past_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!grant_ok || (grant_first >= $past(now_time))));

    p_pair_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_done && grant_ok) |->
            ((grant_first <= grant_time) &&
             ((grant_time >> WIN_LOG2) - (grant_first >> WIN_LOG2) <= TW'(SPLIT_WIN))));

    p_refused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_done && !grant_ok) |-> ((grant_time == '0) && (grant_first == '0)));

    for (genvar i = 0; i < NW; i++) begin : g_occ
        p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
            occ[i] <= CNT_W'(MAX_CMDS));
    end

endmodule

bind cbw_window_sched cbw_window_sched_chk #(
    .TW        (TW),
    .WIN_LOG2  (WIN_LOG2),
    .NWIN_LOG2 (NWIN_LOG2),
    .MAX_CMDS  (MAX_CMDS),
    .SPLIT_WIN (SPLIT_WIN),
    .CNT_W     (CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .now_time    (now_time),
    .grant_done  (grant_done),
    .grant_ok    (grant_ok),
    .grant_first (grant_first),
    .grant_time  (grant_time),
    .occ         (occ)
);

// File: tb/test_cbw_window_sched.sv
`timescale 1ns/1ps
module test_cbw_window_sched;
    localparam int TW        = 32;
    localparam int WIN_LOG2  = 2;
    localparam int NWIN_LOG2 = 3;
    localparam int MAX_CMDS  = 2;
    localparam int SPLIT_WIN = 1;
    localparam longint WIN   = 1 << WIN_LOG2;
    localparam longint NW    = 1 << NWIN_LOG2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_pair = 1'b0;
    logic [TW-1:0] req_time = '0;
    logic [TW-1:0] now_time, grant_first, grant_time;
    logic          grant_done, grant_ok;

    int     n_chk = 0;
    int     n_fail = 0;
    longint now_m = 0;
    int     occ_m [longint];

    cbw_window_sched #(
        .TW(TW), .WIN_LOG2(WIN_LOG2), .NWIN_LOG2(NWIN_LOG2),
        .MAX_CMDS(MAX_CMDS), .SPLIT_WIN(SPLIT_WIN)
    ) i_cbw_window_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pair(req_pair),
        .req_time(req_time), .now_time(now_time), .grant_done(grant_done),
        .grant_ok(grant_ok), .grant_first(grant_first), .grant_time(grant_time)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) now_m <= 0;
        else        now_m <= now_m + 1;
    end

    function automatic void check_eq(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endfunction

    function automatic int occ_of(longint w);
        return occ_m.exists(w) ? occ_m[w] : 0;
    endfunction

    // Reference search built from the requirements, on absolute windows
    function automatic void model(input bit pair, input longint rt,
                                  output bit ok, output longint t1, output longint t2,
                                  output longint fw, output longint sw);
        longint cur = now_m / WIN;
        longint tc  = (rt < now_m) ? now_m : rt;
        longint s0  = tc / WIN;
        longint s   = s0;
        longint f   = s0;
        bit     done_l = 0;
        ok = 0; t1 = 0; t2 = 0;
        if (pair) f = (s0 - SPLIT_WIN < cur) ? cur : s0 - SPLIT_WIN;
        while (!done_l) begin
            if (s - cur >= NW) begin
                ok = 0; done_l = 1;
            end else if (!pair) begin
                if (occ_of(s) < MAX_CMDS) begin ok = 1; done_l = 1; end
                else s++;
            end else begin
                bit same = (f == s);
                int fc = occ_of(f);
                int sc = same ? fc + 1 : occ_of(s);
                bit fok = fc < MAX_CMDS;
                bit sok = sc < MAX_CMDS;
                if (fok && sok) begin
                    ok = 1; done_l = 1;
                end else begin
                    bit gap;
                    if (!sok) s++;
                    gap = !same && ((s - f) > SPLIT_WIN);
                    if (!fok || (!sok && gap)) f++;
                end
            end
        end
        fw = f; sw = s;
        if (ok) begin
            t2 = (s == s0) ? tc : s * WIN;
            t1 = t2;
            if (pair) t1 = (f * WIN < now_m) ? now_m : f * WIN;
        end
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic issue(bit pair, longint rt, string tag);
        bit ok_e; longint t1_e, t2_e, fw, sw;
        model(pair, rt, ok_e, t1_e, t2_e, fw, sw);
        req_valid = 1'b1;
        req_pair  = pair;
        req_time  = TW'(rt);
        @(posedge clk);
        if (ok_e) begin
            occ_m[sw] = occ_of(sw) + 1;
            if (pair) occ_m[fw] = occ_of(fw) + 1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check_eq({tag, " R12 done"}, longint'(grant_done), 1);
        check_eq({tag, " ok"}, longint'(grant_ok), longint'(ok_e));
        check_eq({tag, " time"}, longint'(grant_time), t2_e);
        check_eq({tag, " first"}, longint'(grant_first), t1_e);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
        if (n > 0) begin
            check_eq("R12 idle done", longint'(grant_done), 0);
            check_eq("R2 now", longint'(now_time), now_m);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        longint base;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_eq("R1 now", longint'(now_time), 0);
        check_eq("R1 done", longint'(grant_done), 0);
        // R3: empty window, granted as asked
        issue(0, 5, "R3 single");
        // R5: fill window 1 then overflow into window 2
        issue(0, 6, "R5 second in window");
        issue(0, 7, "R5 overflow");
        check_eq("R5 overflow start", longint'(grant_time), 8);
        // R4: request in the past clamps to now
        issue(0, 0, "R4 clamp");
        idle(3);
        check_eq("R2 now after idle", longint'(now_time), now_m);
        // R7: pair, first part one window earlier
        issue(1, 40, "R7 pair");
        issue(1, 41, "R7 pair again");
        issue(1, 42, "R9 pair pushed");
        // R8: same window, both parts counted
        idle(WIN);
        base = now_m;
        issue(1, base, "R8 same window");
        issue(0, base + 1, "R8 window now full");
        // R11: beyond the table horizon
        base = now_m;
        issue(0, (base / WIN + NW) * WIN, "R11 horizon");
        issue(0, (base / WIN + NW - 1) * WIN, "R11 no reservation kept");
        // R10: fill current window, move on, reuse its entry far ahead
        idle(WIN);
        while ((now_m % WIN) > 1) idle(1);
        base = now_m;
        issue(0, base, "R10 fill");
        issue(0, base, "R10 fill");
        while ((now_m / WIN) == (base / WIN)) idle(1);
        issue(0, (base / WIN + NW) * WIN + 1, "R10 reused entry");
        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            bit     pr = ($urandom_range(0, 2) == 0);
            longint rt = now_m + longint'($urandom_range(0, NW * WIN + 3));
            if ($urandom_range(0, 7) == 0 && now_m > 3) rt = now_m - 3;
            issue(pr, rt, pr ? "R9 random pair" : "R5 random single");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule